// File: doc/BRIEF.md
# Dual-Mode Serial Register Port

This block is a slave serial control port. Through it a host microcontroller reads and writes up to 128 internal 8-bit registers. A session runs while chip select is low and always has sixteen serial clocks. The first eight clocks carry a command byte: a read/write flag followed by a 7-bit register address. The last eight clocks carry the data byte, either into the port or out of it.

The host type is not fixed. Each time chip select falls, the port looks at the serial clock level and chooses one of two behaviours for that session:

- **Serial clock high: shared-pin mode.** Data pin 1 carries traffic in both directions, bits travel least significant first, and data pin 2 is ignored.
- **Serial clock low: split-pin mode.** This is SPI with CPOL=0 and CPHA=0. Data pin 2 receives, data pin 1 only transmits, and bits travel most significant first.

The serial clock, chip select and both data inputs are synchronised into a faster system clock, and all edges are detected in that domain. The register file sits outside the block. It sees:

- an address;
- a one-cycle write strobe with write data;
- a one-cycle read strobe, and it must return read data combinationally in the cycle of that strobe.

Top module: `dual_mode_ctrl_port`

## Requirements
- R1: On each chip-select fall, a high serial clock selects shared-pin mode and a low serial clock selects split-pin mode, for that session only.
- R2: In shared-pin mode, received bits come from `dio1_in`, and `din2` has no effect on the address or the data written.
- R3: In split-pin mode, received bits come from `din2`, and `dio1_in` has no effect.
- R4: The first received bit is the read/write flag (1 = read). The next seven bits are the address: most significant bit first in split-pin mode, least significant bit first in shared-pin mode.
- R5: The data byte, written or read, moves least significant bit first in shared-pin mode and most significant bit first in split-pin mode.
- R6: A write strobe `reg_we` is issued once, one system cycle after the 16th rising serial-clock edge is detected. The rules for an aborted write are:
  - if chip select rises before that edge, no write occurs;
  - if chip select rises in the same synchronised cycle as that edge, the edge does not count and no write occurs.
- R7: For a read, `reg_rd` pulses for one cycle after the 8th rising edge, with `reg_addr` valid. Each falling edge after the 8th through the 15th rising edge drives the next data bit on `dio1_out`.
- R8: `dio1_oe` is low while chip select is high. In split-pin mode it is high for the whole session. In shared-pin mode it is high only from the first data-phase falling edge of a read.
- R9: Serial-clock edges while chip select is high, and clocks beyond the sixteenth, have no effect: no write, no read, no output enable.
- R10: `reg_rdata` is captured in the cycle `reg_rd` is high. `reg_we` and `reg_rd` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from host |
| dio1_in | input | 1 | Data pin 1 input level (receive in shared-pin mode) |
| din2 | input | 1 | Data pin 2 (receive in split-pin mode) |
| dio1_out | output | 1 | Data pin 1 output value |
| dio1_oe | output | 1 | Data pin 1 output enable; low means tri-stated |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | DATA_W | Register write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_rdata | input | DATA_W | Register read data, valid with reg_rd |

## Verification
Two events can land in the same synchronised cycle: the closing rising serial-clock edge and the rise of chip select. That cycle decides whether a write commits or is dropped. The bench provokes it by raising chip select at the very instant of the sixteenth rising clock edge, and expects no write strobe and an unchanged register. A companion case raises chip select half a clock period later and expects exactly one write. A third case ends the session after twelve clocks and also expects the register to stay untouched.

// File: rtl/dual_mode_ctrl_port.sv
module dual_mode_ctrl_port #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              dio1_in,
  input  logic              din2,
  output logic              dio1_out,
  output logic              dio1_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int CMD_BITS = ADDR_W + 1;
  localparam int TOT_BITS = CMD_BITS + DATA_W;
  localparam int CW = $clog2(TOT_BITS + 1);
  localparam logic [CW-1:0] CNT_CMD = CW'(CMD_BITS);
  localparam logic [CW-1:0] CNT_END = CW'(TOT_BITS);

  logic [1:0] cs_sy, sck_sy, d1_sy, d2_sy;
  logic cs_q, sck_q;
  logic bidir, rw;
  logic [CW-1:0] cnt;
  logic [ADDR_W-1:0] addr_sh;
  logic [DATA_W-1:0] data_sh, tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy  <= 2'b11;
      sck_sy <= 2'b00;
      d1_sy  <= 2'b00;
      d2_sy  <= 2'b00;
      cs_q   <= 1'b1;
      sck_q  <= 1'b0;
    end else begin
      cs_sy  <= {cs_sy[0], cs_n};
      sck_sy <= {sck_sy[0], sclk};
      d1_sy  <= {d1_sy[0], dio1_in};
      d2_sy  <= {d2_sy[0], din2};
      cs_q   <= cs_sy[1];
      sck_q  <= sck_sy[1];
    end
  end

  wire cs_s     = cs_sy[1];
  wire sck_s    = sck_sy[1];
  wire cs_fall  = cs_q & ~cs_s;
  wire cs_rise  = ~cs_q & cs_s;
  wire in_sess  = ~cs_q & ~cs_s;
  wire sck_rise = in_sess & sck_s & ~sck_q;
  wire sck_fall = in_sess & ~sck_s & sck_q;
  wire rx_bit   = bidir ? d1_sy[1] : d2_sy[1];
  wire tx_phase = rw && (cnt >= CNT_CMD) && (cnt < CNT_END);

  assign reg_addr  = addr_sh;
  assign reg_wdata = data_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bidir   <= 1'b0;
      rw      <= 1'b0;
      cnt     <= '0;
      addr_sh <= '0;
      data_sh <= '0;
    end else if (cs_fall) begin
      bidir <= sck_s;
      rw    <= 1'b0;
      cnt   <= '0;
    end else if (sck_rise && cnt != CNT_END) begin
      cnt <= cnt + CW'(1);
      if (cnt == '0)
        rw <= rx_bit;
      else if (cnt < CNT_CMD)
        addr_sh <= bidir ? {rx_bit, addr_sh[ADDR_W-1:1]} : {addr_sh[ADDR_W-2:0], rx_bit};
      else if (!rw)
        data_sh <= bidir ? {rx_bit, data_sh[DATA_W-1:1]} : {data_sh[DATA_W-2:0], rx_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_we <= 1'b0;
      reg_rd <= 1'b0;
    end else begin
      reg_we <= sck_rise && (cnt == CNT_END - CW'(1)) && !rw;
      reg_rd <= sck_rise && (cnt == CNT_CMD - CW'(1)) && rw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh    <= '0;
      dio1_out <= 1'b0;
      dio1_oe  <= 1'b0;
    end else if (cs_s || cs_rise) begin
      dio1_oe  <= 1'b0;
      dio1_out <= 1'b0;
    end else if (cs_fall) begin
      dio1_oe  <= ~sck_s;
      dio1_out <= 1'b0;
    end else if (reg_rd) begin
      tx_sh <= reg_rdata;
    end else if (sck_fall && tx_phase) begin
      dio1_oe  <= 1'b1;
      dio1_out <= bidir ? tx_sh[0] : tx_sh[DATA_W-1];
      tx_sh    <= bidir ? (tx_sh >> 1) : (tx_sh << 1);
    end
  end

  p_oe_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !dio1_oe);
  p_oe_bidir_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dio1_oe && bidir) |-> rw);
  p_we_in_session_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !cs_q);
  p_we_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  p_rd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_rd));
endmodule

// File: tb/dual_mode_ctrl_port_tb.sv
module dual_mode_ctrl_port_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, dio1_in = 1'b0, din2 = 1'b0;
  logic dio1_out, dio1_oe, reg_we, reg_rd;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [128];
  int wr_cnt = 0, rd_cnt = 0, total = 0, fails = 0;
  logic [6:0] last_rd_addr = '0;
  logic oe_seen = 1'b0;
  logic [7:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_mode_ctrl_port dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .dio1_in(dio1_in), .din2(din2),
    .dio1_out(dio1_out), .dio1_oe(dio1_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rd(reg_rd), .reg_rdata(reg_rdata));

  assign reg_rdata = mem[reg_addr];

  always @(negedge clk) begin
    if (reg_we) begin
      mem[reg_addr] = reg_wdata;
      wr_cnt++;
    end
    if (reg_rd) begin
      rd_cnt++;
      last_rd_addr = reg_addr;
    end
    if (dio1_oe) oe_seen = 1'b1;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic session(input bit bidir, input bit rw, input logic [6:0] a, input logic [7:0] d,
                         input int nclk, input bit same_edge_end, output logic [7:0] r);
    logic [15:0] st;
    st[0] = rw;
    for (int k = 0; k < 7; k++) st[1+k] = bidir ? a[k] : a[6-k];
    for (int k = 0; k < 8; k++) st[8+k] = bidir ? d[k] : d[7-k];
    r = '0;
    sclk = bidir;
    wait_clk(6);
    oe_seen = 1'b0;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nclk; i++) begin
      logic b;
      b = (i < 16) ? st[i] : 1'b1;
      sclk = 1'b0;
      if (bidir) begin dio1_in = b; din2 = ~b; end
      else begin din2 = b; dio1_in = ~b; end
      wait_clk(HALF);
      if (rw && i >= 8 && i < 16) begin
        if (bidir) r[i-8] = dio1_out;
        else r[15-i] = dio1_out;
      end
      sclk = 1'b1;
      if (same_edge_end && i == nclk - 1) cs_n = 1'b1;
      wait_clk(HALF);
    end
    if (!same_edge_end) begin
      if (!bidir) sclk = 1'b0;
      wait_clk(HALF);
      cs_n = 1'b1;
    end
    wait_clk(10);
    sclk = bidir;
    check(dio1_oe == 1'b0, "R8 oe off after cs high", dio1_oe, 0);
  endtask

  task automatic t_reset;
    check(dio1_oe == 1'b0, "R8 reset oe", dio1_oe, 0);
    check(reg_we == 1'b0 && reg_rd == 1'b0, "R10 reset strobes", {reg_we, reg_rd}, 0);
  endtask

  task automatic t_split_write;
    int w0 = wr_cnt;
    session(1'b0, 1'b0, 7'h5A, 8'hC3, 16, 1'b0, rd);
    check(mem[7'h5A] == 8'hC3, "R3 R4 R5 split write data", mem[7'h5A], 8'hC3);
    check(wr_cnt == w0 + 1, "R6 one write", wr_cnt - w0, 1);
    check(oe_seen == 1'b1, "R8 split drives pin 1", oe_seen, 1);
  endtask

  task automatic t_bidir_write;
    int w0 = wr_cnt;
    session(1'b1, 1'b0, 7'h21, 8'h96, 16, 1'b0, rd);
    check(mem[7'h21] == 8'h96, "R1 R2 shared write data", mem[7'h21], 8'h96);
    check(wr_cnt == w0 + 1, "R6 one shared write", wr_cnt - w0, 1);
    check(oe_seen == 1'b0, "R8 shared write keeps pin 1 off", oe_seen, 0);
  endtask

  task automatic t_split_read;
    int r0 = rd_cnt, w0 = wr_cnt;
    session(1'b0, 1'b1, 7'h5A, 8'h0F, 16, 1'b0, rd);
    check(rd == 8'hC3, "R7 R5 split read data", rd, 8'hC3);
    check(last_rd_addr == 7'h5A && rd_cnt == r0 + 1, "R10 read strobe address", last_rd_addr, 7'h5A);
    check(wr_cnt == w0, "R7 read causes no write", wr_cnt - w0, 0);
  endtask

  task automatic t_bidir_read;
    session(1'b1, 1'b1, 7'h21, 8'hF0, 16, 1'b0, rd);
    check(rd == 8'h96, "R7 R5 shared read data", rd, 8'h96);
    check(oe_seen == 1'b1, "R8 shared read enables pin 1", oe_seen, 1);
  endtask

  task automatic t_bit_order;
    logic [7:0] m40 = mem[7'h40];
    session(1'b1, 1'b0, 7'h01, 8'h01, 16, 1'b0, rd);
    check(mem[7'h01] == 8'h01, "R4 R5 shared lsb-first", mem[7'h01], 8'h01);
    check(mem[7'h40] == m40, "R4 shared no msb-first decode", mem[7'h40], m40);
  endtask

  task automatic t_abort;
    int w0 = wr_cnt;
    logic [7:0] m10 = mem[7'h10];
    session(1'b0, 1'b0, 7'h10, 8'h77, 12, 1'b0, rd);
    check(wr_cnt == w0 && mem[7'h10] == m10, "R6 early cs rise aborts", wr_cnt - w0, 0);
    session(1'b0, 1'b0, 7'h10, 8'h77, 16, 1'b1, rd);
    check(wr_cnt == w0 && mem[7'h10] == m10, "R6 cs rise with last edge aborts", wr_cnt - w0, 0);
  endtask

  task automatic t_extra;
    int w0 = wr_cnt;
    session(1'b0, 1'b0, 7'h11, 8'h3C, 20, 1'b0, rd);
    check(wr_cnt == w0 + 1, "R9 extra clocks single write", wr_cnt - w0, 1);
    check(mem[7'h11] == 8'h3C, "R9 extra clocks data", mem[7'h11], 8'h3C);
  endtask

  task automatic t_idle_toggle;
    int w0 = wr_cnt, r0 = rd_cnt;
    oe_seen = 1'b0;
    for (int i = 0; i < 12; i++) begin
      sclk = ~sclk;
      dio1_in = i[0];
      din2 = i[1];
      wait_clk(HALF);
    end
    wait_clk(8);
    check(wr_cnt == w0 && rd_cnt == r0, "R9 idle clocks no access", wr_cnt - w0 + rd_cnt - r0, 0);
    check(oe_seen == 1'b0, "R9 idle clocks no enable", oe_seen, 0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'(i) ^ 8'hA5;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_split_write();
    t_bidir_write();
    t_split_read();
    t_bidir_read();
    t_bit_order();
    t_abort();
    t_extra();
    t_idle_toggle();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule